// File: doc/BRIEF.md
# Shared-Line Serial Port Expander Sequencer

This block lets a host reach many more parallel pins than it has. It drives an external chain of shift and latch registers over a synchronous serial link: one shift clock, one bidirectional data line, and two strobes. The input-capture strobe makes an external parallel-in register snapshot its pins. The output-latch strobe moves the contents of an external serial-in chain onto its parallel outputs.

A write takes one byte from the host and shifts it out least significant bit first. It then pulses the output-latch strobe for one shift-clock period. A read raises the capture strobe for one shift-clock period. It then clocks eight bits in from the data line, drops the strobe and presents the byte.

The data line is shared. The sequencer enables its own driver only while a write is shifting. The external input driver is enabled only by the capture strobe. A read also ripples through the downstream output chain, but it never pulses the output latch, so the latched outputs keep their value.

Both request inputs use a valid/ready handshake. A request is taken on a cycle where valid and ready are both high. Ready is low for the whole transfer. A source may hold valid through a busy period, but each cycle it does so while the block is busy sets the sticky error flag. The read result is a one-cycle `rd_valid` pulse and cannot be back-pressured: the host must take it in that cycle.

Top module: `sio_expander_ctrl`

## Requirements
- R1: A write is accepted when `wr_valid` and `wr_ready` are both high, and `wr_ready` equals not-busy. A read is accepted when `rd_req_valid` and `rd_req_ready` are both high, and `rd_req_ready` is high only when the block is idle and `wr_valid` is low. A write therefore wins over a read in the same cycle.
- R2: One half-period of `sclk` lasts `div_cfg`+1 system cycles (H), using the `div_cfg` value sampled at acceptance. `sclk` idles high. Each transfer has eight low-then-high clock periods.
- R3: During a write, bit k of the byte (k=0 first) is on `sdata_o` for the whole of low half k and high half k. `sdata_oe` is high for exactly the 16 shifting half-periods, starting the cycle after acceptance.
- R4: After the eighth high half of a write, `out_latch` is high for 2H cycles (one shift-clock period) while `sclk` stays high. The external latch then holds the written byte.
- R5: For a read, `in_ctl` rises in the cycle after acceptance. It stays high for 2H cycles with `sclk` high before the first low half.
- R6: A read samples `sdata_i` in the last system cycle of each low half of `sclk`. The k-th sample becomes bit k of `rd_data`.
- R7: `in_ctl` falls when the 16th shifting half of a read ends. `in_ctl` and `sdata_oe` are never high together.
- R8: A read never raises `out_latch`, so the external latched outputs keep the last written byte.
- R9: `busy` is high for exactly 18H cycles from the cycle after acceptance. `done` is high for one cycle, the first idle cycle after every transfer.
- R10: `rd_valid` is high with `done` after reads only, and `rd_data` then carries the received byte.
- R11: A request (`wr_valid` or `rd_req_valid`) during a busy cycle is not accepted and sets `err`. `err` stays set until a cycle with `err_clr` high and no new violation.
- R12: After reset: `sclk`=1; `sdata_oe`, `in_ctl`, `out_latch`, `busy`, `done`, `rd_valid` and `err` are 0; both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | DIV_W | Half-period length minus one, in system cycles |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with valid |
| wr_data | input | DATA_W | Byte to send |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted when high with valid |
| rd_valid | output | 1 | One-cycle pulse: received byte present |
| rd_data | output | DATA_W | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Sticky request-while-busy flag |
| err_clr | input | 1 | Clears `err` |
| sclk | output | 1 | Shift clock to the external chain |
| sdata_o | output | 1 | Outgoing value for the shared data line |
| sdata_oe | output | 1 | Enable for the block's data-line driver |
| sdata_i | input | 1 | Value read from the shared data line |
| in_ctl | output | 1 | Input-capture strobe, also enables the external driver |
| out_latch | output | 1 | Output-latch strobe |

## Verification
The bench attacks four weak spots:
- Divider off by one: with `div_cfg` at 0 every half is a single cycle, and an off-by-one divider would show at once on `sclk` and `busy`.
- Wrong shift or sample edge: alternating and single-bit bytes, both written and read, expose data shifted on the wrong edge or sampled one half late. Either fault yields a rotated or bit-shifted byte in the external latch or in `rd_data`.
- Read pulsing the latch: after a read, the bench checks the external latch still holds the previous write. A design that pulsed the latch after reads would load it with the input word that rippled through the chain.
- Busy and priority handling: a request during a transfer, and a write and read in the same idle cycle, catch a block that starts a second transfer, forgets the error, or favours the read.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSHIFT = 3'd1,
    ST_LATCH  = 3'd2,
    ST_CAPT   = 3'd3,
    ST_RSHIFT = 3'd4
  } sio_st_e;
endpackage

// File: rtl/sio_halfclk_div.sv
module sio_halfclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div_in;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_shreg.sv
module sio_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              in_bit,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {in_bit, q[DATA_W-1:1]};
  end
endmodule

// File: rtl/sio_seq.sv
module sio_seq
  import sio_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STB_HALVES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_rd,
  input  logic tick,
  output logic busy,
  output logic sclk,
  output logic oe,
  output logic in_ctl,
  output logic out_latch,
  output logic shift_out,
  output logic sample,
  output logic done,
  output logic done_rd
);
  localparam int HALF_N = 2 * DATA_W;
  localparam int HC_MAX = (HALF_N > STB_HALVES) ? HALF_N : STB_HALVES;
  localparam int HC_W   = $clog2(HC_MAX);
  localparam logic [HC_W-1:0] LAST_SH  = HC_W'(HALF_N - 1);
  localparam logic [HC_W-1:0] LAST_STB = HC_W'(STB_HALVES - 1);

  sio_st_e         st, st_n;
  logic [HC_W-1:0] hc, hc_n;
  logic            fin;

  always_comb begin
    st_n = st;
    hc_n = hc;
    fin  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_wr) begin
          st_n = ST_WSHIFT;
          hc_n = '0;
        end else if (start_rd) begin
          st_n = ST_CAPT;
          hc_n = '0;
        end
      end
      ST_WSHIFT: if (tick) begin
        if (hc == LAST_SH) begin
          st_n = ST_LATCH;
          hc_n = '0;
        end else hc_n = hc + 1'b1;
      end
      ST_LATCH: if (tick) begin
        if (hc == LAST_STB) begin
          st_n = ST_IDLE;
          hc_n = '0;
          fin  = 1'b1;
        end else hc_n = hc + 1'b1;
      end
      ST_CAPT: if (tick) begin
        if (hc == LAST_STB) begin
          st_n = ST_RSHIFT;
          hc_n = '0;
        end else hc_n = hc + 1'b1;
      end
      ST_RSHIFT: if (tick) begin
        if (hc == LAST_SH) begin
          st_n = ST_IDLE;
          hc_n = '0;
          fin  = 1'b1;
        end else hc_n = hc + 1'b1;
      end
      default: begin
        st_n = ST_IDLE;
        hc_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hc        <= '0;
      done      <= 1'b0;
      done_rd   <= 1'b0;
      sclk      <= 1'b1;
      oe        <= 1'b0;
      in_ctl    <= 1'b0;
      out_latch <= 1'b0;
    end else begin
      st        <= st_n;
      hc        <= hc_n;
      done      <= fin;
      done_rd   <= fin && (st == ST_RSHIFT);
      sclk      <= (st_n == ST_WSHIFT || st_n == ST_RSHIFT) ? hc_n[0] : 1'b1;
      oe        <= (st_n == ST_WSHIFT);
      in_ctl    <= (st_n == ST_CAPT || st_n == ST_RSHIFT);
      out_latch <= (st_n == ST_LATCH);
    end
  end

  assign busy      = (st != ST_IDLE);
  assign shift_out = tick && (st == ST_WSHIFT) && hc[0];
  assign sample    = tick && (st == ST_RSHIFT) && !hc[0];
endmodule

// File: rtl/sio_expander_ctrl.sv
module sio_expander_ctrl #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              err_clr,
  output logic              sclk,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i,
  output logic              in_ctl,
  output logic              out_latch
);
  logic acc_wr, acc_rd, tick, shift_out, sample;
  logic [DATA_W-1:0] sh_q;

  assign wr_ready     = !busy;
  assign rd_req_ready = !busy && !wr_valid;
  assign acc_wr       = wr_valid && wr_ready;
  assign acc_rd       = rd_req_valid && rd_req_ready;

  sio_halfclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(acc_wr || acc_rd),
    .div_in(div_cfg), .run(busy), .tick(tick)
  );

  sio_seq #(.DATA_W(DATA_W), .STB_HALVES(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(acc_wr), .start_rd(acc_rd),
    .tick(tick), .busy(busy), .sclk(sclk), .oe(sdata_oe),
    .in_ctl(in_ctl), .out_latch(out_latch), .shift_out(shift_out),
    .sample(sample), .done(done), .done_rd(rd_valid)
  );

  sio_shreg #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(acc_wr || acc_rd),
    .load_val(acc_wr ? wr_data : '0), .shift(shift_out || sample),
    .in_bit(sample ? sdata_i : 1'b0), .q(sh_q)
  );

  assign sdata_o = sh_q[0];
  assign rd_data = sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  err <= 1'b0;
    else if (busy && (wr_valid || rd_req_valid)) err <= 1'b1;
    else if (err_clr)                            err <= 1'b0;
  end
endmodule

// File: rtl/sio_expander_ctrl_chk.sv
module sio_expander_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic rd_valid,
  input logic busy,
  input logic done,
  input logic err,
  input logic err_clr,
  input logic sclk,
  input logic sdata_oe,
  input logic in_ctl,
  input logic out_latch
);
  assert_no_drive_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdata_oe && in_ctl));
  assert_no_latch_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ctl |-> !out_latch);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_rdvalid_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);
  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && !in_ctl && !out_latch && !sdata_oe));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> busy);
endmodule

bind sio_expander_ctrl sio_expander_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
  .err_clr(err_clr), .sclk(sclk), .sdata_oe(sdata_oe), .in_ctl(in_ctl),
  .out_latch(out_latch)
);

// File: tb/tb_sio_expander_ctrl.sv
`timescale 1ns/1ps
module tb_sio_expander_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_cfg = '0;
  logic wr_valid = 1'b0, rd_req_valid = 1'b0, err_clr = 1'b0, sdata_i = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rd_req_ready, rd_valid, busy, done, err;
  logic sclk, sdata_o, sdata_oe, in_ctl, out_latch;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  sio_expander_ctrl dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 write, 2 read
  int mst = 0, mc = 0, mh = 1, mlast = 0;
  bit mdone = 0, merr = 0;
  logic [7:0] mbyte = '0, mpw = '0, cur_pw = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mc = 0; mdone = 0; merr = 0;
    end else begin
      if (mst != 0 && (wr_valid || rd_req_valid)) merr = 1;
      else if (err_clr) merr = 0;
      mdone = 0;
      if (mst != 0) begin
        mc++;
        if (mc == 18 * mh) begin mlast = mst; mst = 0; mdone = 1; end
      end else if (wr_valid) begin
        mst = 1; mc = 0; mh = int'(div_cfg) + 1; mbyte = wr_data;
      end else if (rd_req_valid) begin
        mst = 2; mc = 0; mh = int'(div_cfg) + 1; mpw = cur_pw;
      end
    end
  end

  // external chain model
  bit p_sclk = 1, p_in = 0, p_lat = 0;
  logic [7:0] chain = '0, latched = '0;
  int bidx = 0;

  always @(negedge clk) begin
    int h;
    bit e_sclk, e_oe, e_in, e_lat, e_bit, line;
    if (rst_n) begin
      h = mc / mh;
      e_sclk = 1; e_oe = 0; e_in = 0; e_lat = 0; e_bit = 0;
      if (mst == 1) begin
        if (h < 16) begin e_sclk = h[0]; e_oe = 1; e_bit = mbyte[h/2]; end
        else e_lat = 1;
      end else if (mst == 2) begin
        e_in = 1;
        if (h >= 2) e_sclk = (h - 2) % 2;
      end
      chk(sclk == e_sclk, "R2 sclk", sclk, e_sclk);
      chk(sdata_oe == e_oe, "R3 sdata_oe", sdata_oe, e_oe);
      if (e_oe) chk(sdata_o == e_bit, "R3 sdata_o", sdata_o, e_bit);
      chk(in_ctl == e_in, "R5 R7 in_ctl", in_ctl, e_in);
      chk(out_latch == e_lat, "R4 R8 out_latch", out_latch, e_lat);
      chk(busy == (mst != 0), "R9 busy", busy, mst != 0);
      chk(done == mdone, "R9 done", done, mdone);
      chk(rd_valid == (mdone && mlast == 2), "R10 rd_valid", rd_valid, mdone && mlast == 2);
      if (mdone && mlast == 2) chk(rd_data == mpw, "R6 R10 rd_data", rd_data, mpw);
      chk(err == merr, "R11 err", err, merr);
      chk(wr_ready == (mst == 0), "R1 wr_ready", wr_ready, mst == 0);
      chk(rd_req_ready == (mst == 0 && !wr_valid), "R1 rd_req_ready", rd_req_ready,
          mst == 0 && !wr_valid);
      line = sdata_oe ? sdata_o : (in_ctl ? sdata_i : 1'b1);
      if (sclk && !p_sclk) chain = {line, chain[7:1]};
      if (in_ctl && !p_in) begin bidx = 0; sdata_i = cur_pw[0]; end
      else if (in_ctl && sclk && !p_sclk) begin
        bidx++;
        if (bidx < 8) sdata_i = cur_pw[bidx];
      end
      if (!in_ctl) sdata_i = 1'b0;
      if (out_latch && !p_lat) latched = chain;
      p_sclk = sclk; p_in = in_ctl; p_lat = out_latch;
    end
  end

  task automatic do_wr(input logic [7:0] b, input int dv);
    @(negedge clk); div_cfg = 8'(dv); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
    repeat (18 * (dv + 1) + 2) @(negedge clk);
    chk(latched == b, "R4 latch holds written byte", latched, b);
  endtask

  task automatic do_rd(input logic [7:0] pw, input int dv, input logic [7:0] keep);
    @(negedge clk); div_cfg = 8'(dv); cur_pw = pw; rd_req_valid = 1;
    @(negedge clk); rd_req_valid = 0;
    repeat (18 * (dv + 1) + 2) @(negedge clk);
    chk(latched == keep, "R8 latch unchanged by read", latched, keep);
    chk(rd_data == pw, "R6 rd_data", rd_data, pw);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sclk == 1 && !busy && !done && !err && !sdata_oe && !in_ctl && !out_latch
        && wr_ready && rd_req_ready && !rd_valid, "R12 reset state", {sclk, busy, err}, 3'b100);
    do_wr(8'hA5, 0);
    do_wr(8'h3C, 2);
    do_rd(8'h96, 1, 8'h3C);
    do_rd(8'h01, 0, 8'h3C);
    do_rd(8'h80, 3, 8'h3C);
    // R1: write wins when both requests arrive in one idle cycle
    @(negedge clk); div_cfg = 0; wr_valid = 1; wr_data = 8'h0F; rd_req_valid = 1; cur_pw = 8'hFF;
    @(negedge clk); wr_valid = 0; rd_req_valid = 0;
    chk(in_ctl == 0, "R1 write priority", in_ctl, 0);
    repeat (20) @(negedge clk);
    chk(latched == 8'h0F, "R1 write priority latch", latched, 8'h0F);
    chk(err == 0, "R11 no error on idle request", err, 0);
    // R11: request during a busy transfer
    @(negedge clk); div_cfg = 3; wr_valid = 1; wr_data = 8'h5A;
    @(negedge clk); wr_valid = 0;
    repeat (5) @(negedge clk);
    rd_req_valid = 1; cur_pw = 8'hC3;
    @(negedge clk); rd_req_valid = 0;
    chk(err == 1, "R11 err set", err, 1);
    repeat (80) @(negedge clk);
    chk(latched == 8'h5A && err == 1, "R11 dropped request and sticky err",
        {latched, err}, {8'h5A, 1'b1});
    err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk(err == 0, "R11 err cleared", err, 0);
    do_wr(8'hFF, 1);
    do_rd(8'h55, 0, 8'hFF);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule